// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes six external interrupt pins and turns pin transitions into pending request flags for a separate priority arbiter. Each channel has a byte-wide control register on a simple CPU register bus. The register holds a three-bit priority level, the pending flag, an edge-polarity bit and one reserved storage bit. A shared register holds one both-edges override bit per channel.

Each pin goes through a synchronizer before its edge detector. A detected edge of the selected kind latches the channel's pending flag. The block presents each channel's request and priority level to the arbiter. Software can clear a pending flag, but it can never set one, so a register write cannot create a false request. The arbiter can also clear a flag with an acknowledge that carries a channel index.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Register addresses 0 to 5 select the control registers of channels 0 to 5. The control register layout is: bits 2:0 level, bit 3 pending flag, bit 4 polarity, bit 5 reserved storage, bits 7:6 always read 0 and ignore writes. Address 6 holds the both-edges bits, one per channel in bits 5:0, with bits 7:6 reading 0. Level, polarity, reserved and both-edges bits read back what was last written.
- R2: After reset every register reads 0, and `irq_req` and `irq_lvl` are all zero.
- R3: With polarity 0, a falling pin edge sets the pending flag; with polarity 1, a rising edge sets it. The opposite edge has no effect. The flag is visible on the third rising clock edge after the pin changes.
- R4: When a channel's both-edges bit is 1, either pin edge sets its pending flag, whatever the polarity bit holds.
- R5: A register write with bit 3 = 0 clears the pending flag. A write with bit 3 = 1 leaves the flag unchanged, so it never sets a clear flag.
- R6: A detected edge sets the pending flag even at level 0. `irq_req` for a channel is 1 only when its flag is 1 and its level is not 0. `irq_lvl` bits [3i+2:3i] always show channel i's level.
- R7: With `ack_valid` high, the flag of channel `ack_ch` clears on the next clock edge, and the other channels are unaffected.
- R8: If an edge is detected in the same cycle as a software clear or an acknowledge for that channel, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 6 | External interrupt pins, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ack_valid | input | 1 | Arbiter acknowledge strobe |
| ack_ch | input | 3 | Channel index being acknowledged |
| irq_req | output | 6 | Per-channel request to the arbiter |
| irq_lvl | output | 18 | Per-channel priority level, 3 bits each |

## Verification
The in-module assertions check four rules on every cycle. A flag never becomes set without a detected edge. A detected edge always leaves the flag set. An acknowledge with no edge clears the flag. Configuration bits change only when written. The bench scenarios cover what the assertions cannot see. These are the three-cycle latency from pin to flag, the choice of edge under each polarity and under the both-edges override, the gating of requests at level 0, the read-back layout, and the exact cycle in which an edge coincides with a clear. A randomized phase mixes pin toggles, register writes and acknowledges. It compares every register and output against a bench model after each operation.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int unsigned LVL_W    = 3;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned FLAG_BIT = 3;
   localparam int unsigned POL_BIT  = 4;
   localparam int unsigned RSV_BIT  = 5;

   typedef logic [BYTE_W-1:0] reg_byte_t;
   typedef logic [LVL_W-1:0]  lvl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ext_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], d};
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
   parameter bit BOTH_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic pol,
   input  logic both,
   output logic hit
);
   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;

   if (BOTH_EN) begin : g_both
      assign hit = both ? (rise | fall) : (pol ? rise : fall);
   end else begin : g_single
      logic unused_both;
      assign unused_both = both;
      assign hit = pol ? rise : fall;
   end
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
   import ext_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          BOTH_EN     = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  logic      both,
   input  logic      wr_en,
   input  reg_byte_t wdata,
   input  logic      ack_hit,
   output reg_byte_t rd_byte,
   output logic      req,
   output lvl_t      lvl
);
   logic pin_s;
   logic edge_hit;
   lvl_t lvl_q;
   logic flag_q;
   logic pol_q;
   logic rsv_q;
   logic sw_clr;
   logic unused_hi;

   assign unused_hi = ^wdata[BYTE_W-1:RSV_BIT+1];

   ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
   );

   ext_irq_edge #(.BOTH_EN(BOTH_EN)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig(pin_s), .pol(pol_q), .both(both), .hit(edge_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         pol_q <= 1'b0;
         rsv_q <= 1'b0;
      end else if (wr_en) begin
         lvl_q <= wdata[LVL_W-1:0];
         pol_q <= wdata[POL_BIT];
         rsv_q <= wdata[RSV_BIT];
      end
   end

   assign sw_clr = wr_en & ~wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (edge_hit)         flag_q <= 1'b1;
      else if (sw_clr | ack_hit) flag_q <= 1'b0;
   end

   assign rd_byte = {2'b00, rsv_q, pol_q, flag_q, lvl_q};
   assign req     = flag_q & (lvl_q != '0);
   assign lvl     = lvl_q;

   AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !edge_hit) |=> !flag_q); // R7
   AST_NO_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !edge_hit) |=> !flag_q); // R5
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({lvl_q, pol_q, rsv_q})); // R1
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 6,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          BOTH_EN     = 1'b1,
   localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       irq_pin,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [BYTE_W-1:0]       bus_wdata,
   output logic [BYTE_W-1:0]       bus_rdata,
   input  logic                    ack_valid,
   input  logic [CH_W-1:0]         ack_ch,
   output logic [NUM_CH-1:0]       irq_req,
   output logic [NUM_CH*LVL_W-1:0] irq_lvl
);
   localparam int unsigned BOTH_ADDR = NUM_CH;

   if (NUM_CH < 1 || NUM_CH > BYTE_W) begin : g_bad_num
      $error("ext_irq_ctrl: NUM_CH must be 1..8");
   end
   if ((1 << ADDR_W) <= NUM_CH) begin : g_bad_addr
      $error("ext_irq_ctrl: ADDR_W too narrow for the register map");
   end

   logic                bus_we;
   logic                both_we;
   logic [NUM_CH-1:0]   both_q;
   reg_byte_t           rd_byte [NUM_CH];

   assign bus_we  = bus_sel & bus_wr;
   assign both_we = bus_we & (bus_addr == ADDR_W'(BOTH_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       both_q <= '0;
      else if (both_we) both_q <= bus_wdata[NUM_CH-1:0];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic wr_en_i;
      logic ack_i;
      assign wr_en_i = bus_we & (bus_addr == ADDR_W'(i));
      assign ack_i   = ack_valid & (ack_ch == CH_W'(i));

      ext_irq_chan #(.SYNC_STAGES(SYNC_STAGES), .BOTH_EN(BOTH_EN)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (irq_pin[i]),
         .both    (both_q[i]),
         .wr_en   (wr_en_i),
         .wdata   (bus_wdata),
         .ack_hit (ack_i),
         .rd_byte (rd_byte[i]),
         .req     (irq_req[i]),
         .lvl     (irq_lvl[i*LVL_W +: LVL_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(i)) bus_rdata = rd_byte[i];
      end
      if (bus_addr == ADDR_W'(BOTH_ADDR)) bus_rdata[NUM_CH-1:0] = both_q;
   end

   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !both_we |=> $stable(both_q)); // R4
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
   localparam int NCH = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  irq_pin = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        ack_valid = 1'b0;
   logic [2:0]  ack_ch = '0;
   logic [5:0]  irq_req;
   logic [17:0] irq_lvl;

   int checks = 0;
   int errors = 0;

   logic [2:0] m_lvl  [NCH];
   logic       m_flag [NCH];
   logic       m_pol  [NCH];
   logic       m_rsv  [NCH];
   logic       m_both [NCH];

   always #4 clk = ~clk;

   ext_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ack_valid(ack_valid), .ack_ch(ack_ch), .irq_req(irq_req), .irq_lvl(irq_lvl)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = 3'(a);
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic ack(input int ch);
      ack_valid = 1'b1; ack_ch = 3'(ch);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_pin = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
         m_lvl[i] = '0; m_flag[i] = 1'b0; m_pol[i] = 1'b0; m_rsv[i] = 1'b0; m_both[i] = 1'b0;
      end
   endtask

   function automatic logic [7:0] exp_ctrl(input int ch);
      return {2'b00, m_rsv[ch], m_pol[ch], m_flag[ch], m_lvl[ch]};
   endfunction

   function automatic logic [7:0] exp_both();
      logic [7:0] v = '0;
      for (int i = 0; i < NCH; i++) v[i] = m_both[i];
      return v;
   endfunction

   function automatic logic [5:0] exp_req();
      logic [5:0] v;
      for (int i = 0; i < NCH; i++) v[i] = m_flag[i] && (m_lvl[i] != 3'd0);
      return v;
   endfunction

   function automatic logic [17:0] exp_lvl();
      logic [17:0] v;
      for (int i = 0; i < NCH; i++) v[i*3 +: 3] = m_lvl[i];
      return v;
   endfunction

   task automatic compare_all(input string req);
      logic [7:0] d;
      for (int a = 0; a < NCH; a++) begin
         rd(a, d);
         check(req, $sformatf("ctrl reg %0d", a), 32'(d), 32'(exp_ctrl(a)));
      end
      rd(NCH, d);
      check(req, "both reg", 32'(d), 32'(exp_both()));
      check(req, "irq_req", 32'(irq_req), 32'(exp_req()));
      check(req, "irq_lvl", 32'(irq_lvl), 32'(exp_lvl()));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      do_reset();
      // R2: reset state
      compare_all("R2");
      rd(7, d);
      check("R1", "unmapped address", 32'(d), 32'h0);

      // R1/R5: upper bits ignored, write of 1 to clear flag does not set it
      wr(0, 8'hFF);
      rd(0, d);
      check("R1", "ch0 readback of FF", 32'(d), 32'h37);
      check("R5", "ch0 req after FF", 32'(irq_req[0]), 32'h0);

      // R3: rising edge with polarity 1
      wr(0, 8'h17);
      @(negedge clk); irq_pin[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      #1 check("R3", "flag before 3rd edge", 32'(irq_req[0]), 32'h0);
      @(negedge clk);
      #1 check("R3", "req at 3rd edge", 32'(irq_req[0]), 32'h1);
      rd(0, d);
      check("R3", "ch0 flag set", 32'(d), 32'h1F);
      wr(0, 8'h17);
      rd(0, d);
      check("R5", "ch0 cleared by write 0", 32'(d), 32'h17);
      irq_pin[0] = 1'b0; settle();
      rd(0, d);
      check("R3", "falling edge ignored at pol 1", 32'(d), 32'h17);

      // R6: level 0 still latches, request gated
      wr(1, 8'h00);
      irq_pin[1] = 1'b1; settle();
      rd(1, d);
      check("R3", "rising ignored at pol 0", 32'(d), 32'h00);
      irq_pin[1] = 1'b0; settle();
      rd(1, d);
      check("R6", "flag set at level 0", 32'(d), 32'h08);
      check("R6", "req gated at level 0", 32'(irq_req[1]), 32'h0);
      wr(1, 8'h0A);
      #1 check("R6", "req after level 2", 32'(irq_req[1]), 32'h1);
      check("R6", "irq_lvl ch1", 32'(irq_lvl[5:3]), 32'h2);

      // R7: acknowledge clears only the indexed channel
      wr(2, 8'h05);
      irq_pin[2] = 1'b1; settle();
      irq_pin[2] = 1'b0; settle();
      ack(1);
      #1 check("R7", "ch1 cleared by ack", 32'(irq_req[1]), 32'h0);
      check("R7", "ch2 kept", 32'(irq_req[2]), 32'h1);

      // R4: both-edges override
      wr(6, 8'hC8);
      rd(6, d);
      check("R1", "both reg readback", 32'(d), 32'h08);
      wr(3, 8'h13);
      irq_pin[3] = 1'b1; settle();
      check("R4", "both: rise", 32'(irq_req[3]), 32'h1);
      ack(3);
      irq_pin[3] = 1'b0; settle();
      check("R4", "both: fall at pol 1", 32'(irq_req[3]), 32'h1);

      // R8: edge coincides with acknowledge
      irq_pin[3] = 1'b1;
      @(negedge clk); @(negedge clk);
      ack(3);
      #1 check("R8", "edge wins over ack", 32'(irq_req[3]), 32'h1);
      @(negedge clk);
      #1 check("R8", "flag stays after ack", 32'(irq_req[3]), 32'h1);
      // R8: edge coincides with software clear
      irq_pin[3] = 1'b0;
      @(negedge clk); @(negedge clk);
      wr(3, 8'h13);
      @(negedge clk);
      rd(3, d);
      check("R8", "edge wins over soft clear", 32'(d), 32'h1B);

      // randomized phase against the bench model
      do_reset();
      void'($urandom(32'd20417));
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 9);
         int ch = $urandom_range(0, NCH - 1);
         if (op <= 4) begin
            logic nv = ~irq_pin[ch];
            irq_pin[ch] = nv;
            if (m_both[ch] || (m_pol[ch] ? nv : !nv)) m_flag[ch] = 1'b1;
            settle();
            compare_all(m_both[ch] ? "R4" : "R3");
         end else if (op <= 6) begin
            logic [7:0] v = 8'($urandom);
            wr(ch, v);
            m_lvl[ch] = v[2:0]; m_pol[ch] = v[4]; m_rsv[ch] = v[5];
            m_flag[ch] = m_flag[ch] & v[3];
            compare_all("R5");
         end else if (op == 7) begin
            logic [7:0] v = 8'($urandom);
            wr(6, v);
            for (int i = 0; i < NCH; i++) m_both[i] = v[i];
            compare_all("R1");
         end else if (op == 8) begin
            ack(ch);
            m_flag[ch] = 1'b0;
            compare_all("R7");
         end else begin
            @(negedge clk);
            compare_all("R6");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule